// File: doc/BRIEF.md
# Strip Readout Zero Suppressor

This block sits behind the digitizer of one 128-channel strip front-end chip. Raw samples arrive channel after channel, each channel carrying a configured number of time samples (1 to 16). For every sample, the block subtracts a per-channel pedestal and sums the signed result over the channel's samples. A channel is kept when its mean corrected charge reaches a noise threshold. That threshold is the channel's pedestal standard deviation scaled by a user factor. To avoid a divider, the test is done as `sum * 256 >= nsamp * sigma * factor`.

Kept channels are written into an output buffer while the frame is still coming in. After the last channel has been evaluated, the block streams out one packet of 16-bit words. The packet is a four-word chip header followed by one section per kept channel. A per-chip bypass keeps every well-formed channel. Channels whose sample count differs from the configured count are flagged in the header error byte and dropped. The pedestal and sigma tables are loaded through a one-cycle write port.

Top module: `zs_strip_suppressor`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `out_valid` and `out_last` are low and `in_ready` is high.
- R2: Without bypass, a channel of correct length is kept exactly when `S * 256 >= nsamp * sigma * factor`. S is the signed sum of (sample - pedestal) over the channel's samples. `factor` is unsigned with 8 fractional bits. Equality keeps the channel, and a zero or negative S never beats a positive threshold.
- R3: With `cfg_bypass` high, every channel whose sample count equals `cfg_nsamp` is kept, whatever its charge.
- R4: Each packet starts with four header words. Word 0 is {chip id zero-extended to 8 bits, count of kept channels}. Word 1 is {`cfg_nsamp` as 8 bits, error byte}. Words 2 and 3 are zero.
- R5: Each kept channel is sent as one word {8'h00, channel index} followed by `cfg_nsamp` words. Each of these carries the raw input sample in bits [12:0], with bits [15:13] zero, in arrival order. The channel index counts channels within the frame from 0, a channel ending at the sample flagged `in_last`. Sections appear in ascending channel order.
- R6: Error byte bit 0 is set when any channel in the frame had fewer samples than `cfg_nsamp`, and bit 1 when any had more. Bits [7:2] are zero. A channel of the wrong length is never kept, even in bypass.
- R7: `in_ready` falls in the cycle after the last sample of channel 127 is accepted and stays low until the final word of the packet is presented. The packet words come on consecutive cycles, and `out_last` is high on the final word only.
- R8: A table write with `cfg_we` high uses `cfg_addr[7]` to pick the sigma table (1) or the pedestal table (0), and `cfg_addr[6:0]` to pick the channel. The pedestal takes `cfg_wdata[12:0]` and sigma takes `cfg_wdata[9:0]`. Frames sent after the write use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 8 | Table select (bit 7) and channel (bits 6:0) |
| cfg_wdata | input | 16 | Table write data |
| cfg_chip_id | input | 4 | Chip identifier placed in the header |
| cfg_nsamp | input | 5 | Expected samples per channel, 1 to 16 |
| cfg_factor | input | 10 | Threshold factor, 8 fractional bits |
| cfg_bypass | input | 1 | Keep all well-formed channels |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts samples |
| in_sample | input | 13 | Raw digitized sample |
| in_last | input | 1 | Last sample of the current channel |
| out_valid | output | 1 | Packet word present |
| out_data | output | 16 | Packet word |
| out_last | output | 1 | Final word of the packet |

## Verification
The checker assumes that `cfg_nsamp` lies between 1 and 16 and that no configuration input changes while a frame is being collected or sent. Its header checks compare the sample-count byte against the live `cfg_nsamp`. The bench therefore changes configuration only after the previous packet has fully left. It waits for `in_ready` before presenting each sample and inserts idle gaps in the input stream. Every frame holds exactly 128 channels, and frames with deliberately short and long channels exercise the error byte.

// File: rtl/zs_pkg.sv
package zs_pkg;

    localparam int WORD_W    = 16;
    localparam int HDR_WORDS = 4;
    localparam int FRAC_BITS = 8;

    typedef enum logic [1:0] {
        EM_IDLE,
        EM_PREP,
        EM_SEND
    } emit_state_e;

    typedef struct packed {
        logic [7:0] chip;
        logic [7:0] nchan;
        logic [7:0] nsamp;
        logic [7:0] err;
    } pkt_hdr_t;

    typedef struct packed {
        logic long_seen;
        logic short_seen;
    } len_flags_t;

    function automatic logic [WORD_W-1:0] hdr_word(input pkt_hdr_t h, input logic [1:0] sel);
        case (sel)
            2'd0:    return {h.chip, h.nchan};
            2'd1:    return {h.nsamp, h.err};
            default: return '0;
        endcase
    endfunction

    function automatic logic [7:0] err_byte(input len_flags_t f);
        return {6'b0, f.long_seen, f.short_seen};
    endfunction

endpackage

// File: rtl/zs_cal_tables.sv
module zs_cal_tables
    import zs_pkg::*;
#(
    parameter int NUM_CH = 128,
    parameter int ADC_W  = 13,
    parameter int SIG_W  = 10,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_sigma,
    input  logic [CH_W-1:0]   wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [CH_W-1:0]   rd_idx,
    output logic [ADC_W-1:0]  rd_ped,
    output logic [SIG_W-1:0]  rd_sig
);

    logic [ADC_W-1:0] ped_q [NUM_CH];
    logic [SIG_W-1:0] sig_q [NUM_CH];

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_idx) < NUM_CH)) begin
            if (wr_sigma) begin
                sig_q[wr_idx] <= wr_data[SIG_W-1:0];
            end else begin
                ped_q[wr_idx] <= wr_data[ADC_W-1:0];
            end
        end
    end

    assign rd_ped = ped_q[rd_idx];
    assign rd_sig = sig_q[rd_idx];

endmodule

// File: rtl/zs_chan_eval.sv
module zs_chan_eval
    import zs_pkg::*;
#(
    parameter int NUM_CH   = 128,
    parameter int MAX_SAMP = 16,
    parameter int ADC_W    = 13,
    parameter int SIG_W    = 10,
    parameter int FAC_W    = 10,
    parameter int CH_W     = $clog2(NUM_CH),
    parameter int NS_W     = $clog2(MAX_SAMP + 1),
    parameter int ADDR_W   = $clog2(NUM_CH * (MAX_SAMP + 1))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADC_W-1:0]  sample,
    input  logic              last,
    input  logic [ADC_W-1:0]  ped,
    input  logic [SIG_W-1:0]  sig,
    input  logic [NS_W-1:0]   nsamp,
    input  logic [FAC_W-1:0]  factor,
    input  logic              bypass,
    input  logic              frame_clr,
    output logic [CH_W-1:0]   chan_idx,
    output logic              frame_done,
    output logic              wa_en,
    output logic [ADDR_W-1:0] wa_addr,
    output logic [WORD_W-1:0] wa_data,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [WORD_W-1:0] wb_data,
    output logic [7:0]        kept_cnt,
    output len_flags_t        flags,
    output logic [ADDR_W-1:0] fill
);

    localparam int CNT_W = NS_W + 1;
    localparam int ACC_W = ADC_W + 1 + $clog2(MAX_SAMP);
    localparam int THR_W = NS_W + SIG_W + FAC_W;
    localparam int LHS_W = ACC_W + FRAC_BITS;
    localparam int CMP_W = ((LHS_W > THR_W) ? LHS_W : THR_W) + 1;

    logic [CNT_W-1:0]        samp_cnt;
    logic signed [ACC_W-1:0] acc;
    logic [CH_W-1:0]         chan;
    logic [ADDR_W-1:0]       wr_base;

    logic [CNT_W-1:0]        ns_ext;
    logic [CNT_W-1:0]        cnt_fin;
    logic                    in_win;
    logic signed [ADC_W:0]   diff;
    logic signed [ACC_W-1:0] diff_ext;
    logic signed [ACC_W-1:0] acc_next;
    logic [THR_W-1:0]        thr;
    logic signed [CMP_W-1:0] lhs;
    logic signed [CMP_W-1:0] rhs;
    logic                    is_short;
    logic                    is_long;
    logic                    keep;
    logic                    last_chan;

    assign ns_ext   = CNT_W'(nsamp);
    assign in_win   = samp_cnt < ns_ext;
    assign cnt_fin  = (samp_cnt == '1) ? samp_cnt : samp_cnt + 1'b1;
    assign diff     = $signed({1'b0, sample}) - $signed({1'b0, ped});
    assign diff_ext = ACC_W'(diff);
    assign acc_next = in_win ? (acc + diff_ext) : acc;

    assign thr = THR_W'(nsamp) * THR_W'(sig) * THR_W'(factor);
    assign lhs = CMP_W'(acc_next) <<< FRAC_BITS;
    assign rhs = $signed(CMP_W'(thr));

    assign is_short  = cnt_fin < ns_ext;
    assign is_long   = cnt_fin > ns_ext;
    assign keep      = !is_short && !is_long && (bypass || (lhs >= rhs));
    assign last_chan = (chan == CH_W'(NUM_CH - 1));

    assign wa_en   = accept && in_win;
    assign wa_addr = wr_base + ADDR_W'(samp_cnt) + 1'b1;
    assign wa_data = WORD_W'(sample);
    assign wb_en   = accept && (samp_cnt == '0);
    assign wb_addr = wr_base;
    assign wb_data = WORD_W'(chan);

    assign frame_done = accept && last && last_chan;
    assign chan_idx   = chan;
    assign fill       = wr_base;

    always_ff @(posedge clk) begin
        if (rst || frame_clr) begin
            samp_cnt <= '0;
            acc      <= '0;
            chan     <= '0;
            wr_base  <= '0;
            kept_cnt <= '0;
            flags    <= '0;
        end else if (accept) begin
            if (last) begin
                samp_cnt         <= '0;
                acc              <= '0;
                chan             <= last_chan ? '0 : chan + 1'b1;
                flags.short_seen <= flags.short_seen | is_short;
                flags.long_seen  <= flags.long_seen | is_long;
                if (keep) begin
                    wr_base  <= wr_base + ADDR_W'(nsamp) + 1'b1;
                    kept_cnt <= kept_cnt + 1'b1;
                end
            end else begin
                samp_cnt <= cnt_fin;
                acc      <= acc_next;
            end
        end
    end

endmodule

// File: rtl/zs_packet_buffer.sv
module zs_packet_buffer
    import zs_pkg::*;
#(
    parameter int DEPTH  = 2176,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wa_en,
    input  logic [ADDR_W-1:0] wa_addr,
    input  logic [WORD_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [WORD_W-1:0] wb_data,
    input  logic              start,
    input  logic [ADDR_W-1:0] fill,
    input  pkt_hdr_t          hdr,
    output logic              busy,
    output logic              frame_clr,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last
);

    logic [WORD_W-1:0] mem [DEPTH];

    emit_state_e       state;
    logic [LEN_W-1:0]  idx;
    logic [LEN_W-1:0]  total;
    logic              is_hdr;
    logic              at_end;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] body_word;

    always_ff @(posedge clk) begin
        if (wa_en) begin
            mem[wa_addr] <= wa_data;
        end
        if (wb_en) begin
            mem[wb_addr] <= wb_data;
        end
    end

    assign total     = LEN_W'(fill) + LEN_W'(HDR_WORDS);
    assign is_hdr    = idx < LEN_W'(HDR_WORDS);
    assign at_end    = (idx == total - 1'b1);
    assign rd_addr   = ADDR_W'(idx - LEN_W'(HDR_WORDS));
    assign body_word = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : '0;
    assign busy      = (state != EM_IDLE);
    assign frame_clr = (state == EM_SEND) && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= EM_IDLE;
            idx       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else begin
            case (state)
                EM_IDLE: begin
                    out_valid <= 1'b0;
                    out_last  <= 1'b0;
                    if (start) begin
                        state <= EM_PREP;
                    end
                end
                EM_PREP: begin
                    idx   <= '0;
                    state <= EM_SEND;
                end
                EM_SEND: begin
                    out_valid <= 1'b1;
                    out_data  <= is_hdr ? hdr_word(hdr, idx[1:0]) : body_word;
                    out_last  <= at_end;
                    idx       <= idx + 1'b1;
                    if (at_end) begin
                        state <= EM_IDLE;
                    end
                end
                default: state <= EM_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/zs_strip_suppressor.sv
module zs_strip_suppressor
    import zs_pkg::*;
#(
    parameter int NUM_CH   = 128,
    parameter int MAX_SAMP = 16,
    parameter int ADC_W    = 13,
    parameter int SIG_W    = 10,
    parameter int FAC_W    = 10,
    parameter int ID_W     = 4,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int NS_W    = $clog2(MAX_SAMP + 1),
    localparam int DEPTH   = NUM_CH * (MAX_SAMP + 1),
    localparam int ADDR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CH_W:0]     cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic [ID_W-1:0]   cfg_chip_id,
    input  logic [NS_W-1:0]   cfg_nsamp,
    input  logic [FAC_W-1:0]  cfg_factor,
    input  logic              cfg_bypass,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADC_W-1:0]  in_sample,
    input  logic              in_last,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last
);

    logic              accept;
    logic              busy;
    logic              frame_clr;
    logic              frame_done;
    logic [CH_W-1:0]   chan_idx;
    logic [ADC_W-1:0]  cur_ped;
    logic [SIG_W-1:0]  cur_sig;
    logic              wa_en;
    logic [ADDR_W-1:0] wa_addr;
    logic [WORD_W-1:0] wa_data;
    logic              wb_en;
    logic [ADDR_W-1:0] wb_addr;
    logic [WORD_W-1:0] wb_data;
    logic [7:0]        kept_cnt;
    len_flags_t        flags;
    logic [ADDR_W-1:0] fill;
    pkt_hdr_t          hdr;

    assign in_ready = !busy;
    assign accept   = in_valid && in_ready;

    assign hdr.chip  = 8'(cfg_chip_id);
    assign hdr.nchan = kept_cnt;
    assign hdr.nsamp = 8'(cfg_nsamp);
    assign hdr.err   = err_byte(flags);

    zs_cal_tables #(
        .NUM_CH (NUM_CH),
        .ADC_W  (ADC_W),
        .SIG_W  (SIG_W),
        .CH_W   (CH_W)
    ) u_tables (
        .clk      (clk),
        .wr_en    (cfg_we),
        .wr_sigma (cfg_addr[CH_W]),
        .wr_idx   (cfg_addr[CH_W-1:0]),
        .wr_data  (cfg_wdata),
        .rd_idx   (chan_idx),
        .rd_ped   (cur_ped),
        .rd_sig   (cur_sig)
    );

    zs_chan_eval #(
        .NUM_CH   (NUM_CH),
        .MAX_SAMP (MAX_SAMP),
        .ADC_W    (ADC_W),
        .SIG_W    (SIG_W),
        .FAC_W    (FAC_W),
        .CH_W     (CH_W),
        .NS_W     (NS_W),
        .ADDR_W   (ADDR_W)
    ) u_eval (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .sample     (in_sample),
        .last       (in_last),
        .ped        (cur_ped),
        .sig        (cur_sig),
        .nsamp      (cfg_nsamp),
        .factor     (cfg_factor),
        .bypass     (cfg_bypass),
        .frame_clr  (frame_clr),
        .chan_idx   (chan_idx),
        .frame_done (frame_done),
        .wa_en      (wa_en),
        .wa_addr    (wa_addr),
        .wa_data    (wa_data),
        .wb_en      (wb_en),
        .wb_addr    (wb_addr),
        .wb_data    (wb_data),
        .kept_cnt   (kept_cnt),
        .flags      (flags),
        .fill       (fill)
    );

    zs_packet_buffer #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_buffer (
        .clk       (clk),
        .rst       (rst),
        .wa_en     (wa_en),
        .wa_addr   (wa_addr),
        .wa_data   (wa_data),
        .wb_en     (wb_en),
        .wb_addr   (wb_addr),
        .wb_data   (wb_data),
        .start     (frame_done),
        .fill      (fill),
        .hdr       (hdr),
        .busy      (busy),
        .frame_clr (frame_clr),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

endmodule

// File: rtl/zs_checker.sv
module zs_checker #(
    parameter int NUM_CH = 128,
    parameter int NS_W   = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            in_ready,
    input logic [NS_W-1:0] cfg_nsamp,
    input logic            out_valid,
    input logic [15:0]     out_data,
    input logic            out_last
);

    logic [15:0] pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (out_valid) begin
            pos <= out_last ? '0 : ((pos == 16'hFFFF) ? pos : pos + 1'b1);
        end
    end

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !out_last && in_ready)); // R1

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pos == 16'd0) |-> (int'(out_data[7:0]) <= NUM_CH)); // R4

    AST_HDR_SAMPLE_COUNT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pos == 16'd1) |-> (out_data[15:8] == 8'(cfg_nsamp))); // R4

    AST_HDR_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (pos == 16'd2 || pos == 16'd3)) |-> (out_data == 16'd0)); // R4

    AST_ERR_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pos == 16'd1) |-> (out_data[7:2] == 6'd0)); // R6

    AST_WORDS_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid); // R7

    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid); // R7

    AST_INPUT_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |-> !in_ready); // R7

endmodule

bind zs_strip_suppressor zs_checker #(
    .NUM_CH (NUM_CH),
    .NS_W   (NS_W)
) u_zs_checker (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .cfg_nsamp (cfg_nsamp),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/zs_strip_suppressor_bench.sv
module zs_strip_suppressor_bench;

    localparam int NUM_CH   = 128;
    localparam int MAX_SAMP = 16;
    localparam int XTRA     = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [3:0]  cfg_chip_id = '0;
    logic [4:0]  cfg_nsamp = 5'd1;
    logic [9:0]  cfg_factor = '0;
    logic        cfg_bypass = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [12:0] in_sample = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_last;

    always #2 clk = ~clk;

    zs_strip_suppressor u_zs_strip_suppressor (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_chip_id(cfg_chip_id), .cfg_nsamp(cfg_nsamp), .cfg_factor(cfg_factor),
        .cfg_bypass(cfg_bypass), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .in_last(in_last), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] exp_data [$];
    logic        exp_last [$];
    string       exp_req  [$];

    int ped_tb [NUM_CH];
    int sig_tb [NUM_CH];
    int raw_tb [NUM_CH][MAX_SAMP + XTRA];
    int len_tb [NUM_CH];

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        logic [15:0] d;
        logic        l;
        string       r;
        if (!rst && out_valid) begin
            if (exp_data.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R7 unexpected word actual=%0d expected=none", out_data);
            end else begin
                d = exp_data.pop_front();
                l = exp_last.pop_front();
                r = exp_req.pop_front();
                check(out_data == d, r, "packet word", int'(out_data), int'(d));
                check(out_last == l, "R7", "last flag", int'(out_last), int'(l));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R7 watchdog expired actual=%0d expected=0", exp_data.size());
        finish_test();
    end

    task automatic push(input logic [15:0] d, input string r);
        exp_data.push_back(d);
        exp_last.push_back(1'b0);
        exp_req.push_back(r);
    endtask

    task automatic write_tbl(input bit sel_sigma, input int ch, input int val);
        @(posedge clk); #1;
        cfg_we    = 1'b1;
        cfg_addr  = {sel_sigma, 7'(ch)};
        cfg_wdata = 16'(val);
        @(posedge clk); #1;
        cfg_we    = 1'b0;
    endtask

    function automatic int amp_of(input int mode, input int c, input int k);
        if (mode == 1) begin
            return ((c % 2) == 1 && k == 3) ? 7 : 8;
        end
        case (c % 5)
            0:       return 40 + k * 5;
            1:       return 0;
            2:       return -15;
            3:       return (c % 11) - 3;
            default: return 2 + k;
        endcase
    endfunction

    task automatic gen_frame(input int mode);
        for (int c = 0; c < NUM_CH; c++) begin
            len_tb[c] = int'(cfg_nsamp);
            for (int k = 0; k < MAX_SAMP + XTRA; k++) begin
                raw_tb[c][k] = ped_tb[c] + amp_of(mode, c, k);
            end
        end
    endtask

    // expected packet from R2..R6
    task automatic build_expected(input string chan_req);
        int  kept = 0;
        bit  sh = 0;
        bit  lg = 0;
        bit  keepc [NUM_CH];
        int  ns = int'(cfg_nsamp);
        for (int c = 0; c < NUM_CH; c++) begin
            int s = 0;
            for (int k = 0; k < ns && k < len_tb[c]; k++) s += raw_tb[c][k] - ped_tb[c];
            if (len_tb[c] < ns) sh = 1;
            if (len_tb[c] > ns) lg = 1;
            keepc[c] = (len_tb[c] == ns) &&
                       (cfg_bypass || (s * 256 >= ns * sig_tb[c] * int'(cfg_factor)));
            if (keepc[c]) kept++;
        end
        push({4'h0, cfg_chip_id, 8'(kept)}, "R4");
        push({8'(ns), 6'b0, lg, sh}, "R6");
        push(16'h0, "R4");
        push(16'h0, "R4");
        for (int c = 0; c < NUM_CH; c++) begin
            if (keepc[c]) begin
                push({8'h00, 8'(c)}, chan_req);
                for (int k = 0; k < ns; k++) push(16'(raw_tb[c][k]), "R5");
            end
        end
        exp_last[exp_last.size() - 1] = 1'b1;
    endtask

    task automatic drive_frame();
        for (int c = 0; c < NUM_CH; c++) begin
            for (int k = 0; k < len_tb[c]; k++) begin
                if (((c + k) % 7) == 3) begin
                    @(posedge clk); #1;
                end
                while (!in_ready) begin
                    @(posedge clk); #1;
                end
                in_valid  = 1'b1;
                in_sample = 13'(raw_tb[c][k]);
                in_last   = (k == len_tb[c] - 1);
                @(posedge clk); #1;
                in_valid  = 1'b0;
                in_last   = 1'b0;
            end
        end
        check(in_ready == 1'b0, "R7", "in_ready after last channel", int'(in_ready), 0);
        while (exp_data.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
        check(in_ready == 1'b1, "R7", "in_ready after packet", int'(in_ready), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

        // R8: load both tables through the write port
        for (int c = 0; c < NUM_CH; c++) begin
            ped_tb[c] = 300 + (c * 37) % 500;
            sig_tb[c] = 4 + (c % 7) * 3;
            write_tbl(1'b0, c, ped_tb[c]);
            write_tbl(1'b1, c, sig_tb[c]);
        end

        // frame 1: threshold decision, factor about 0.8 (R2)
        cfg_chip_id = 4'd5; cfg_nsamp = 5'd4; cfg_factor = 10'd205; cfg_bypass = 1'b0;
        gen_frame(0);
        build_expected("R2");
        drive_frame();

        // frame 2: bypass keeps everything (R3)
        cfg_chip_id = 4'd9; cfg_nsamp = 5'd3; cfg_bypass = 1'b1;
        gen_frame(0);
        build_expected("R3");
        drive_frame();

        // frame 3: short and long channels flagged and dropped (R6)
        cfg_chip_id = 4'd2; cfg_nsamp = 5'd5; cfg_bypass = 1'b1;
        gen_frame(0);
        len_tb[7]  = 4;
        len_tb[9]  = 6;
        len_tb[20] = 2;
        build_expected("R6");
        drive_frame();

        // frame 4: rewritten sigma, exact threshold equality (R2 boundary, R8)
        for (int c = 0; c < NUM_CH; c++) begin
            sig_tb[c] = 8;
            write_tbl(1'b1, c, 8);
        end
        cfg_chip_id = 4'd15; cfg_nsamp = 5'd4; cfg_factor = 10'd256; cfg_bypass = 1'b0;
        gen_frame(1);
        build_expected("R2,R8 boundary");
        drive_frame();

        finish_test();
    end

endmodule